// File: doc/BRIEF.md
# Scanline Interrupt Counter with Offset-Shaped Reload

This block raises an interrupt after a programmed number of displayed scanlines. The host CPU writes into a small register group. One command arms the counter. One command stops it and drops the request. One command loads a reload value. A fourth command sets an offset word. While the offset is in use, it reshapes every reload value as that value is written.

Every qualifying scanline pulse advances the counter. A pulse qualifies only when it arrives on a visible line while rendering is on. A reload is pending after an arm command or a reload write. The next qualifying pulse first copies the reload value into the counter. The same pulse then decrements the counter if it is above zero. If the counter then reads zero and the block is armed, the interrupt request rises. The request is a level: it stays high until the CPU issues the stop command.

Top module: `scanline_irq_unit`

## Requirements
- R1: After reset the block is disarmed, the counter, reload value, offset and pending-reload flag are zero, and `irq` is low.
- R2: A write with `wr_sel` = 2 disarms the block and forces `irq` low on the next cycle. This holds even if a qualifying pulse arrives in the same cycle.
- R3: A write with `wr_sel` = 3 arms the block and marks a reload as pending. A qualifying pulse in the same cycle is judged with the arm state from before the write.
- R4: A write with `wr_sel` = 5 while offset bit 7 is clear stores `wr_data | (offset & 0x27)` as the reload value and marks a reload as pending.
- R5: A write with `wr_sel` = 5 while offset bit 7 is set stores `wr_data ^ (offset | 1)` as the reload value.
- R6: A write with `wr_sel` = 6 loads the offset only when parameter `OFFSET_EN` is 1. When `OFFSET_EN` is 0, such a write has no effect and the offset stays zero.
- R7: A scanline pulse changes the counter only when `line_visible` and `render_on` are both high in that cycle.
- R8: A qualifying pulse does three things in order. It loads the counter from the reload value if a reload is pending, and clears the pending flag. It decrements the counter if nonzero. It then sets `irq` if the counter is zero and the block is armed. A reload value N ≥ 1 therefore raises `irq` on the N-th qualifying pulse, and a value of 0 raises it on the first.
- R9: Once high, `irq` stays high until a stop write (`wr_sel` = 2).
- R10: A counter at zero with no pending reload stays at zero on further pulses and does not wrap.
- R11: Writes with `wr_sel` = 0, 1, 4 or 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe into the register group |
| wr_sel | input | 3 | Register select (low address bits) |
| wr_data | input | DATA_W | Write data |
| line_tick | input | 1 | One-cycle pulse per scanline |
| line_visible | input | 1 | High while the current line is a displayed line |
| render_on | input | 1 | High while rendering is enabled |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds two copies of the block side by side with the default 8-bit width and the 0x27 mask. One copy has `OFFSET_EN` = 1 and the other has `OFFSET_EN` = 0. The same writes go to both copies. A single offset write then gives two different firing lines, which shows both the XOR and OR shaping and the case where the offset is ignored. Random traffic is mixed in. It puts writes in the same cycles as pulses, so the priority between stop, arm and pulse is exercised.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
   localparam int SEL_W = 3;
   typedef enum logic [SEL_W-1:0] {
      CMD_STOP   = 3'd2,
      CMD_ARM    = 3'd3,
      CMD_RELOAD = 3'd5,
      CMD_OFFSET = 3'd6
   } sirq_cmd_e;
endpackage

// File: rtl/sirq_latch_fmt.sv
module sirq_latch_fmt #(
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] OR_MASK = 'h27
) (
   input  logic [DATA_W-1:0] raw,
   input  logic [DATA_W-1:0] offset,
   output logic [DATA_W-1:0] shaped
);
   localparam int TOP = DATA_W - 1;
   localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

   always_comb begin
      if (offset[TOP]) shaped = raw ^ (offset | ONE);
      else             shaped = raw | (offset & OR_MASK);
   end
endmodule

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
   import sirq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] OR_MASK = 'h27,
   parameter bit OFFSET_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              line_ok,
   output logic              armed,
   output logic              pending,
   output logic              stop_now,
   output logic [DATA_W-1:0] reload
);
   logic do_stop, do_arm, do_reload, do_offset;
   logic [DATA_W-1:0] offset_q, shaped;

   always_comb begin
      do_stop   = wr_en && (wr_sel == CMD_STOP);
      do_arm    = wr_en && (wr_sel == CMD_ARM);
      do_reload = wr_en && (wr_sel == CMD_RELOAD);
      do_offset = wr_en && (wr_sel == CMD_OFFSET);
   end
   assign stop_now = do_stop;

   generate
      if (OFFSET_EN) begin : g_offset
         always_ff @(posedge clk) begin
            if (!rst_n)         offset_q <= '0;
            else if (do_offset) offset_q <= wr_data;
         end
      end else begin : g_no_offset
         assign offset_q = '0;
         // R6: with the variant off the select-6 write reaches nothing
      end
   endgenerate

   sirq_latch_fmt #(.DATA_W(DATA_W), .OR_MASK(OR_MASK)) u_fmt (
      .raw(wr_data), .offset(offset_q), .shaped(shaped));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         pending <= 1'b0;
         reload  <= '0;
      end else begin
         if (do_stop)     armed <= 1'b0;
         else if (do_arm) armed <= 1'b1;
         if (do_reload) reload <= shaped;
         if (do_arm || do_reload) pending <= 1'b1;
         else if (line_ok)        pending <= 1'b0;
      end
   end

   a_r3_arm_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
      do_arm |=> (armed && pending));
   a_r2_stop_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      do_stop |=> !armed);
endmodule

// File: rtl/sirq_count.sv
module sirq_count #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_ok,
   input  logic              pending,
   input  logic              armed,
   input  logic              stop_now,
   input  logic [DATA_W-1:0] reload,
   output logic              irq
);
   logic [DATA_W-1:0] cnt_q, base, next_cnt;

   always_comb begin
      base     = pending ? reload : cnt_q;
      next_cnt = (base != '0) ? base - 1'b1 : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         irq   <= 1'b0;
      end else begin
         if (line_ok) cnt_q <= next_cnt;
         if (stop_now)                                    irq <= 1'b0;
         else if (line_ok && armed && next_cnt == '0)     irq <= 1'b1;
      end
   end

   a_r7_hold_off_line: assert property (@(posedge clk) disable iff (!rst_n)
      !line_ok |=> $stable(cnt_q));
   a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (line_ok && !pending && cnt_q == '0) |=> (cnt_q == '0));
   a_r9_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !stop_now) |=> irq);
   a_r2_stop_drops: assert property (@(posedge clk) disable iff (!rst_n)
      stop_now |=> !irq);
endmodule

// File: rtl/scanline_irq_unit.sv
module scanline_irq_unit #(
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] OR_MASK = 'h27,
   parameter bit OFFSET_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              line_tick,
   input  logic              line_visible,
   input  logic              render_on,
   output logic              irq
);
   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("DATA_W must be at least 8");
      end
   endgenerate

   logic line_ok, armed, pending, stop_now;
   logic [DATA_W-1:0] reload;

   assign line_ok = line_tick && line_visible && render_on;

   sirq_ctrl #(.DATA_W(DATA_W), .OR_MASK(OR_MASK), .OFFSET_EN(OFFSET_EN)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .line_ok(line_ok), .armed(armed), .pending(pending), .stop_now(stop_now),
      .reload(reload));

   sirq_count #(.DATA_W(DATA_W)) u_count (
      .clk(clk), .rst_n(rst_n), .line_ok(line_ok), .pending(pending), .armed(armed),
      .stop_now(stop_now), .reload(reload), .irq(irq));

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> !irq);
endmodule

// File: tb/sim_scanline_irq_unit.sv
module sim_scanline_irq_unit;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [2:0] wr_sel = '0;
   logic [7:0] wr_data = '0;
   logic line_tick = 1'b0, line_visible = 1'b0, render_on = 1'b0;
   logic irq0, irq1;
   int checks = 0, errors = 0;

   always #2.5 clk = ~clk;

   scanline_irq_unit #(.OFFSET_EN(1'b1)) u0 (
      .clk, .rst_n, .wr_en, .wr_sel, .wr_data, .line_tick, .line_visible, .render_on, .irq(irq0));
   scanline_irq_unit #(.OFFSET_EN(1'b0)) u1 (
      .clk, .rst_n, .wr_en, .wr_sel, .wr_data, .line_tick, .line_visible, .render_on, .irq(irq1));

   // reference state, index 0 = offset variant on, 1 = off
   bit m_en[2], m_pre[2], m_irq[2];
   logic [7:0] m_lat[2], m_off[2], m_cnt[2];

   function automatic logic [7:0] shape(logic [7:0] d, logic [7:0] off);
      return off[7] ? (d ^ (off | 8'h01)) : (d | (off & 8'h27));
   endfunction

   task automatic model_reset();
      for (int k = 0; k < 2; k++) begin
         m_en[k] = 0; m_pre[k] = 0; m_irq[k] = 0;
         m_lat[k] = 0; m_off[k] = 0; m_cnt[k] = 0;
      end
   endtask

   task automatic model_step(bit we, logic [2:0] sel, logic [7:0] d, bit ok);
      for (int k = 0; k < 2; k++) begin
         logic [7:0] b, n;
         bit en_old = m_en[k];
         b = m_pre[k] ? m_lat[k] : m_cnt[k];
         n = (b != 0) ? b - 8'd1 : 8'd0;
         if (ok) m_cnt[k] = n;
         if (we && sel == 3'd2) m_irq[k] = 0;
         else if (ok && en_old && n == 0) m_irq[k] = 1;
         if (ok) m_pre[k] = 0;
         if (we && sel == 3'd2) m_en[k] = 0;
         if (we && sel == 3'd3) begin m_en[k] = 1; m_pre[k] = 1; end
         if (we && sel == 3'd5) begin m_lat[k] = shape(d, m_off[k]); m_pre[k] = 1; end
         if (we && sel == 3'd6 && k == 0) m_off[k] = d;
      end
   endtask

   task automatic check(string tag);
      checks++;
      if (irq0 !== m_irq[0]) begin
         errors++;
         $display("FAIL %s: u0 irq actual %0b expected %0b", tag, irq0, m_irq[0]);
      end
      checks++;
      if (irq1 !== m_irq[1]) begin
         errors++;
         $display("FAIL %s: u1 irq actual %0b expected %0b", tag, irq1, m_irq[1]);
      end
   endtask

   task automatic step(bit we, logic [2:0] sel, logic [7:0] d,
                       bit tk, bit vis, bit ren, string tag);
      wr_en = we; wr_sel = sel; wr_data = d;
      line_tick = tk; line_visible = vis; render_on = ren;
      @(posedge clk);
      model_step(we, sel, d, tk && vis && ren);
      @(negedge clk);
      wr_en = 0; line_tick = 0;
      check(tag);
   endtask

   task automatic wr(logic [2:0] sel, logic [7:0] d, string tag);
      step(1, sel, d, 0, 1, 1, tag);
   endtask

   task automatic ticks(int n, string tag);
      for (int i = 0; i < n; i++) step(0, 0, 0, 1, 1, 1, tag);
   endtask

   initial begin
      fork
         begin
            model_reset();
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            check("R1");
            ticks(5, "R1");                 // disarmed: no irq
            // R4 / R6: offset 0x07, reload 0x10 -> 0x17 on u0, 0x10 on u1
            wr(3'd6, 8'h07, "R6");
            wr(3'd5, 8'h10, "R4");
            wr(3'd3, 8'h00, "R3");
            ticks(24, "R4");
            ticks(6, "R9");
            ticks(4, "R10");
            wr(3'd2, 8'h00, "R2");
            ticks(3, "R2");
            // R5: offset 0x83, reload 0x05 -> 0x86 on u0, 0x05 on u1
            wr(3'd6, 8'h83, "R6");
            wr(3'd5, 8'h05, "R5");
            wr(3'd3, 8'h00, "R3");
            for (int i = 0; i < 10; i++) begin
               step(0, 0, 0, 1, 0, 1, "R7");   // not visible
               step(0, 0, 0, 1, 1, 0, "R7");   // rendering off
               step(0, 0, 0, 0, 1, 1, "R7");   // no pulse
            end
            ticks(3, "R7");
            wr(3'd0, 8'hFF, "R11"); wr(3'd1, 8'hFF, "R11");
            wr(3'd4, 8'hFF, "R11"); wr(3'd7, 8'hFF, "R11");
            ticks(140, "R5");
            wr(3'd2, 8'h00, "R2");
            // R8 corners: reload 0 and 1 fire on first pulse, 2 on second
            wr(3'd6, 8'h00, "R8");
            wr(3'd5, 8'h00, "R8"); wr(3'd3, 0, "R8"); ticks(1, "R8");
            wr(3'd2, 0, "R2");
            wr(3'd5, 8'h01, "R8"); wr(3'd3, 0, "R8"); ticks(1, "R8");
            wr(3'd2, 0, "R2");
            wr(3'd5, 8'h02, "R8"); wr(3'd3, 0, "R8"); ticks(2, "R8");
            // R2: stop with a qualifying pulse in the same cycle
            step(1, 3'd2, 0, 1, 1, 1, "R2");
            // R3: arm together with a pulse
            step(1, 3'd3, 0, 1, 1, 1, "R3");
            ticks(3, "R8");
            // random traffic
            void'($urandom(32'h5C4A11));
            for (int i = 0; i < 4000; i++) begin
               int r = $urandom_range(0, 99);
               logic [2:0] s = 3'($urandom_range(0, 7));
               if (r < 4 && s == 3'd2) s = 3'd5;
               step(r < 12, s, 8'($urandom_range(0, 40)) | (($urandom_range(0, 9) == 0) ? 8'h80 : 8'h00),
                    $urandom_range(0, 3) != 0, $urandom_range(0, 7) != 0,
                    $urandom_range(0, 7) != 0, "R8");
            end
            // R1: reset again mid-activity
            rst_n = 1'b0;
            @(negedge clk);
            rst_n = 1'b1;
            model_reset();
            check("R1");
         end
         begin
            repeat (150000) @(posedge clk);
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule